// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core

This block is a compact 32-bit in-order processor core. It moves every instruction through five stages: fetch, decode with register read, execute or address calculation, data memory access, and register writeback. Each stage takes one clock. It runs a small instruction set: register add, OR with an immediate, word load, word store and branch-if-equal. The core holds its own instruction memory, data memory and a 32-entry register file. A preload write port fills both memories, normally while reset is held.

The full 32-bit instruction word travels down the pipe in one instruction register per stage. Each stage decodes its own control from its own copy, so no control bundle is passed between stages. The core detects no hazards and forwards nothing. Programs must place a producing instruction at least three slots ahead of any consumer, and must accept that the two words after a branch always execute. Each instruction that reaches writeback is reported on a retire port. The port gives the destination register and the value written, which lets a checker follow the program.

Top module: `pipe5_core`

## Requirements
- R1: After reset is released, instruction i of a straight-line run is shown on the retire outputs in the cycle after the (i+4)-th rising edge. A run of N instructions therefore finishes in N + 4 cycles, and the retire strobe stays low for the first three edges.
- R2: Fetch reads the word at byte address PC (word index PC[..:2]) and adds 4 to PC on every edge, unless a taken branch overrides it.
- R3: The add instruction (bits [31:26] = 0, bits [5:0] = 0x20) writes rs + rt, modulo 2^32, to register rd. The rs field is bits [25:21], rt is bits [20:16] and rd is bits [15:11].
- R4: The OR-immediate instruction (bits [31:26] = 0x0D) writes rs OR the zero-extended immediate in bits [15:0] to register rt.
- R5: The load instruction (bits [31:26] = 0x23) writes to register rt the data word at byte address rs + sign-extended immediate. The word index is address[..:2].
- R6: The store instruction (bits [31:26] = 0x2B) writes register rt to the data word at rs + sign-extended immediate during its memory stage. A load in the very next slot sees the new value.
- R7: The branch instruction (bits [31:26] = 0x04) is taken when rs equals rt. It sets PC to (branch address + 4) + (sign-extended immediate × 4). The two words after the branch always execute, and a negative offset branches backward.
- R8: A branch whose operands differ does not change the fetch order.
- R9: Register 0 always reads as zero. A write to register 0 is dropped and shows on the retire port with the write flag low, even when that write is in writeback while register 0 is being read.
- R10: A register written in writeback gives its new value to a decode of the same register in the same cycle. A consumer three slots after its producer therefore reads the new result.
- R11: Reset is asynchronous and active low. It clears PC to 0 and loads the all-zero no-op into every stage register. The retire strobe drops at once, and a reset in the middle of a run restarts the program from address 0.
- R12: The retire strobe is high when the writeback-stage word is nonzero. The write flag, destination and data show the register write that word performs, and the all-zero word is a no-op.
- R13: With the preload enable high, the preload data is written at the rising edge to instruction memory (select = 0) or data memory (select = 1), at the given word index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Preload write enable |
| load_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | LAW (6) | Preload word index |
| load_data | input | XLEN (32) | Preload data word |
| retire_o | output | 1 | A nonzero instruction is in writeback |
| retire_we_o | output | 1 | That instruction writes a nonzero register |
| retire_rd_o | output | 5 | Destination register of the write |
| retire_data_o | output | XLEN (32) | Value written |

## Verification
The main program mixes every instruction kind with no-ops and is checked entry by entry against the retire stream. Immediates with the top bit set show whether zero-extension (OR) or sign-extension (load offset) is applied. Consumers placed exactly three slots after their producers show whether the same-cycle register bypass works. A write to register 0 that lands while register 0 is being read shows that the write is dropped and does not leak through the bypass. A not-taken branch, a forward taken branch and a backward self-loop separate the branch-offset rules from the always-executed delay slots, and a store followed at once by a load of the same word confirms the memory write timing.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int XLEN       = 32,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic            load_dmem,
  input  logic [LAW-1:0]  load_addr,
  input  logic [XLEN-1:0] load_data,
  output logic            retire_o,
  output logic            retire_we_o,
  output logic [4:0]      retire_rd_o,
  output logic [XLEN-1:0] retire_data_o
);
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  function automatic logic is_add(input logic [31:0] w);
    return w[31:26] == OP_RTYPE && w[5:0] == FN_ADD;
  endfunction
  function automatic logic is_op(input logic [31:0] w, input logic [5:0] op);
    return w[31:26] == op;
  endfunction
  function automatic logic [XLEN-1:0] sext(input logic [31:0] w);
    return {{(XLEN-16){w[15]}}, w[15:0]};
  endfunction
  function automatic logic [XLEN-1:0] zext(input logic [31:0] w);
    return {{(XLEN-16){1'b0}}, w[15:0]};
  endfunction

  logic [31:0]     imem_q [IMEM_WORDS];
  logic [XLEN-1:0] dmem_q [DMEM_WORDS];
  logic [XLEN-1:0] rf_q   [32];

  logic [XLEN-1:0] pc_q, pc_id, pc_ex;
  logic [31:0]     ir_id, ir_ex, ir_mem, ir_wb;
  logic [XLEN-1:0] a_ex, b_ex, s_mem, b_mem, s_wb, m_wb;
  logic [1:0]      age_q;

  // decode / register read
  logic [4:0]      id_rs, id_rt;
  logic [XLEN-1:0] id_a, id_b;
  assign id_rs = ir_id[25:21];
  assign id_rt = ir_id[20:16];

  // writeback decode
  logic            wb_we;
  logic [4:0]      wb_dst;
  logic [XLEN-1:0] wb_val;
  assign wb_we  = is_add(ir_wb) || is_op(ir_wb, OP_ORI) || is_op(ir_wb, OP_LW);
  assign wb_dst = is_add(ir_wb) ? ir_wb[15:11] : ir_wb[20:16];
  assign wb_val = is_op(ir_wb, OP_LW) ? m_wb : s_wb;

  logic rf_wen;
  assign rf_wen = wb_we && (wb_dst != 5'd0);

  assign id_a = (id_rs == 5'd0) ? '0 : (rf_wen && wb_dst == id_rs) ? wb_val : rf_q[id_rs];
  assign id_b = (id_rt == 5'd0) ? '0 : (rf_wen && wb_dst == id_rt) ? wb_val : rf_q[id_rt];

  // execute decode
  logic [XLEN-1:0] ex_s, br_target;
  logic            br_taken;
  always_comb begin
    if (is_add(ir_ex))                                 ex_s = a_ex + b_ex;
    else if (is_op(ir_ex, OP_ORI))                     ex_s = a_ex | zext(ir_ex);
    else if (is_op(ir_ex, OP_LW) || is_op(ir_ex, OP_SW)) ex_s = a_ex + sext(ir_ex);
    else                                               ex_s = '0;
  end
  assign br_taken  = is_op(ir_ex, OP_BEQ) && (a_ex == b_ex);
  assign br_target = pc_ex + XLEN'(4) + (sext(ir_ex) << 2);

  // memory decode
  logic           mem_sw;
  logic [DAW-1:0] mem_idx;
  assign mem_sw  = is_op(ir_mem, OP_SW);
  assign mem_idx = s_mem[DAW+1:2];

  logic [IAW-1:0] pc_idx;
  assign pc_idx = pc_q[IAW+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      pc_id  <= '0;
      pc_ex  <= '0;
      ir_id  <= '0;
      ir_ex  <= '0;
      ir_mem <= '0;
      ir_wb  <= '0;
      a_ex   <= '0;
      b_ex   <= '0;
      s_mem  <= '0;
      b_mem  <= '0;
      s_wb   <= '0;
      m_wb   <= '0;
      age_q  <= '0;
    end else begin
      pc_q   <= br_taken ? br_target : pc_q + XLEN'(4);
      ir_id  <= imem_q[pc_idx];
      pc_id  <= pc_q;
      ir_ex  <= ir_id;
      pc_ex  <= pc_id;
      a_ex   <= id_a;
      b_ex   <= id_b;
      ir_mem <= ir_ex;
      s_mem  <= ex_s;
      b_mem  <= b_ex;
      ir_wb  <= ir_mem;
      s_wb   <= s_mem;
      m_wb   <= dmem_q[mem_idx];
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en && !load_dmem) imem_q[load_addr[IAW-1:0]] <= load_data[31:0];
    if (load_en && load_dmem)  dmem_q[load_addr[DAW-1:0]] <= load_data;
    else if (mem_sw)           dmem_q[mem_idx] <= b_mem;
    if (rf_wen)                rf_q[wb_dst] <= wb_val;
  end

  assign retire_o      = ir_wb != 32'd0;
  assign retire_we_o   = rf_wen;
  assign retire_rd_o   = wb_dst;
  assign retire_data_o = wb_val;

  logic unused_bits;
  assign unused_bits = ^{pc_q[1:0], s_mem[1:0], load_addr, load_data};

  // R1: the writeback word is the decode word from three edges earlier
  assert_stage_chain_R1: assert property (@(posedge clk) disable iff (!rst_n || age_q != 2'd3)
    ir_wb == $past(ir_id, 3));

  // R2: without a taken branch the PC steps by one word
  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n || age_q == 2'd0)
    !$past(br_taken) |-> pc_q == $past(pc_q) + XLEN'(4));

  // R7: a taken branch redirects the PC to its target
  assert_branch_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n || age_q == 2'd0)
    $past(br_taken) |-> pc_q == $past(br_target));

  // R6: a store lands in data memory at the end of its memory stage
  assert_store_lands_R6: assert property (@(posedge clk) disable iff (!rst_n || age_q == 2'd0)
    $past(mem_sw && !load_en) |-> dmem_q[$past(mem_idx)] == $past(b_mem));

  // R12: a no-op in writeback never reports a register write
  assert_nop_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !retire_o |-> !retire_we_o);
endmodule

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
  localparam int XLEN = 32;
  localparam int LAW  = 6;
  localparam time CLK = 20ns;
  localparam int NEXP = 28;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            load_en = 1'b0;
  logic            load_dmem = 1'b0;
  logic [LAW-1:0]  load_addr = '0;
  logic [XLEN-1:0] load_data = '0;
  logic            retire_o, retire_we_o;
  logic [4:0]      retire_rd_o;
  logic [XLEN-1:0] retire_data_o;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #(CLK/2) clk = ~clk;

  pipe5_core dut_i (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .retire_o(retire_o),
    .retire_we_o(retire_we_o), .retire_rd_o(retire_rd_o), .retire_data_o(retire_data_o)
  );

  // expected retire stream: {strobe, we, rd, data}
  localparam logic [38:0] EXP [NEXP] = '{
    {1'b1, 1'b1, 5'd1,  32'h0000_0005},  // R4 ori r1
    {1'b1, 1'b1, 5'd2,  32'h0000_8003},  // R4 zero-extend
    {1'b1, 1'b1, 5'd3,  32'h0000_FFFF},  // R4
    {1'b1, 1'b0, 5'd0,  32'h0000_0000},  // R9 write to r0 dropped
    {1'b1, 1'b1, 5'd4,  32'h0000_8008},  // R3 add
    {1'b1, 1'b1, 5'd8,  32'h0000_0020},  // R4
    {1'b1, 1'b1, 5'd5,  32'h0000_FFFF},  // R9 r0 reads zero during its writeback
    {1'b1, 1'b1, 5'd6,  32'h0001_0010},  // R10 bypass at distance three
    {1'b1, 1'b1, 5'd7,  32'h1357_9BDF},  // R5 negative offset
    {1'b0, 1'b0, 5'd0,  32'h0000_0000},  // R12 nop
    {1'b1, 1'b0, 5'd0,  32'h0000_0000},  // R6 store retires without write
    {1'b1, 1'b1, 5'd10, 32'h0001_0010},  // R6 load sees store
    {1'b1, 1'b1, 5'd9,  32'hCAFE_F00D},  // R5 R13 preloaded word
    {1'b1, 1'b0, 5'd0,  32'h0000_0000},  // R8 beq not taken
    {1'b1, 1'b1, 5'd11, 32'h0000_0011},  // R8
    {1'b1, 1'b1, 5'd12, 32'h0000_0012},  // R8
    {1'b1, 1'b1, 5'd13, 32'h0000_0013},  // R8 no skip
    {1'b1, 1'b0, 5'd0,  32'h0000_0000},  // R7 beq taken
    {1'b1, 1'b1, 5'd14, 32'h0000_0014},  // R7 slot one
    {1'b1, 1'b1, 5'd15, 32'h0000_0015},  // R7 slot two
    {1'b1, 1'b1, 5'd17, 32'h0000_0017},  // R7 target, r16 skipped
    {1'b1, 1'b0, 5'd0,  32'h0000_0000},  // R7 backward beq
    {1'b0, 1'b0, 5'd0,  32'h0000_0000},  // R7
    {1'b0, 1'b0, 5'd0,  32'h0000_0000},  // R7
    {1'b1, 1'b0, 5'd0,  32'h0000_0000},  // R7 loop repeats
    {1'b0, 1'b0, 5'd0,  32'h0000_0000},
    {1'b0, 1'b0, 5'd0,  32'h0000_0000},
    {1'b1, 1'b0, 5'd0,  32'h0000_0000}   // R2 R7
  };

  function automatic logic [31:0] enc_add(input logic [4:0] rd, rs, rt);
    return {6'h00, rs, rt, rd, 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rt, rs,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic load_word(input logic sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    load_en = 1'b1; load_dmem = sel; load_addr = LAW'(addr); load_data = data;
  endtask

  task automatic run_trace(input int pass);
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 1; e <= 3; e++) begin
      @(posedge clk); @(negedge clk);
      check($sformatf("R1 R11 fill edge %0d pass %0d", e, pass), 32'(retire_o), 32'd0);
    end
    for (int c = 0; c < NEXP; c++) begin
      @(posedge clk); @(negedge clk);
      check($sformatf("R1/R12 strobe entry %0d pass %0d", c, pass), 32'(retire_o), 32'(EXP[c][38]));
      check($sformatf("R9/R12 write flag entry %0d pass %0d", c, pass), 32'(retire_we_o), 32'(EXP[c][37]));
      if (EXP[c][37]) begin
        check($sformatf("R12 dest entry %0d pass %0d", c, pass), 32'(retire_rd_o), 32'(EXP[c][36:32]));
        check($sformatf("R3/R4/R5 data entry %0d pass %0d", c, pass), retire_data_o, EXP[c][31:0]);
      end
    end
  endtask

  initial begin
    // R13 preload program and data while in reset
    load_word(1'b0, 0,  enc_i(6'h0D, 5'd1, 5'd0, 16'h0005));
    load_word(1'b0, 1,  enc_i(6'h0D, 5'd2, 5'd0, 16'h8003));
    load_word(1'b0, 2,  enc_i(6'h0D, 5'd3, 5'd0, 16'hFFFF));
    load_word(1'b0, 3,  enc_i(6'h0D, 5'd0, 5'd0, 16'h1234));
    load_word(1'b0, 4,  enc_add(5'd4, 5'd1, 5'd2));
    load_word(1'b0, 5,  enc_i(6'h0D, 5'd8, 5'd0, 16'h0020));
    load_word(1'b0, 6,  enc_add(5'd5, 5'd3, 5'd0));
    load_word(1'b0, 7,  enc_add(5'd6, 5'd4, 5'd4));
    load_word(1'b0, 8,  enc_i(6'h23, 5'd7, 5'd8, 16'hFFF8));
    load_word(1'b0, 9,  32'd0);
    load_word(1'b0, 10, enc_i(6'h2B, 5'd6, 5'd0, 16'h0010));
    load_word(1'b0, 11, enc_i(6'h23, 5'd10, 5'd0, 16'h0010));
    load_word(1'b0, 12, enc_i(6'h23, 5'd9, 5'd0, 16'h0008));
    load_word(1'b0, 13, enc_i(6'h04, 5'd2, 5'd1, 16'h0005));
    load_word(1'b0, 14, enc_i(6'h0D, 5'd11, 5'd0, 16'h0011));
    load_word(1'b0, 15, enc_i(6'h0D, 5'd12, 5'd0, 16'h0012));
    load_word(1'b0, 16, enc_i(6'h0D, 5'd13, 5'd0, 16'h0013));
    load_word(1'b0, 17, enc_i(6'h04, 5'd5, 5'd3, 16'h0003));
    load_word(1'b0, 18, enc_i(6'h0D, 5'd14, 5'd0, 16'h0014));
    load_word(1'b0, 19, enc_i(6'h0D, 5'd15, 5'd0, 16'h0015));
    load_word(1'b0, 20, enc_i(6'h0D, 5'd16, 5'd0, 16'h0016));
    load_word(1'b0, 21, enc_i(6'h0D, 5'd17, 5'd0, 16'h0017));
    load_word(1'b0, 22, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
    load_word(1'b0, 23, 32'd0);
    load_word(1'b0, 24, 32'd0);
    load_word(1'b1, 2,  32'hCAFE_F00D);
    load_word(1'b1, 4,  32'hDEAD_BEEF);
    load_word(1'b1, 6,  32'h1357_9BDF);
    @(negedge clk);
    load_en = 1'b0;
    check("R11 strobe low in reset", 32'(retire_o), 32'd0);

    run_trace(0);

    // R11 mid-run reset restarts from address 0
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 strobe drops on async reset", 32'(retire_o), 32'd0);
    load_word(1'b1, 4, 32'hDEAD_BEEF);
    @(negedge clk);
    load_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 strobe low while reset held", 32'(retire_o), 32'd0);
    run_trace(1);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule